// File: doc/BRIEF.md
# Hot-Plug Slot Command Controller

This block is the command engine of a bridge that manages a small set of hot-pluggable slots. Software writes a 16-bit command word made of a command code byte and a target slot byte. One cycle later the block decodes the code and checks it against the current state of the slots. It then updates each affected slot's 2-bit state field and its power and attention indicator fields. It also rewrites a 4-bit command status word and sets a sticky command-detected flag, which software clears by writing a one to it.

The code byte carries three packed subfields for single-slot operations. Two further code groups exist. One sets the secondary bus speed, and only one speed is legal. The other holds two broadcast commands that drive every slot to power-only or to enabled, chosen per slot by its latch input. A broadcast is refused as a whole when any slot is already enabled. Card-present inputs seed the slot states at reset, and latch-open inputs steer the broadcast commands.

Top module: `hp_slot_ctrl`

## Requirements
- R1: A synchronous reset, with rst_n low, puts each slot whose slot_present bit is 1 into state enabled (2) with power indicator on (1), and each other slot into state disabled (3) with power indicator off (3). Every attention field, cmd_status and cmd_detected reset to 0. In the packed outputs, slot i sits at bits [2i+1:2i].
- R2: Codes 0x00..0x3F are single-slot operations. Code bits [1:0] are the requested state (0 keep, 1 power-only, 2 enabled, 3 disabled), bits [3:2] the power indicator and bits [5:4] the attention indicator. Indicator values are 0 keep, 1 on, 2 blink, 3 off, and a value of 0 leaves the field untouched.
- R3: Only the low 5 bits of the target byte are used, and the addressed slot is target-1. A target of 0 or above NUM_SLOTS sets invalid-command (cmd_status bit 2) and changes no slot.
- R4: A single-slot request for power-only on a slot that is enabled sets invalid-command and changes neither the state nor the indicators of that slot.
- R5: A slot state changes only from disabled to power-only, from disabled to enabled, or from enabled or power-only to disabled. Any other request keeps the state but still applies the indicator fields.
- R6: Codes 0x40..0x47 select the bus speed from bits [2:0]. A speed of 0 is accepted with no error. Any other speed sets invalid-mode (cmd_status bit 3). Neither case changes any slot.
- R7: Code 0x48 (all power-only) and code 0x49 (all enabled) set invalid-command and change no slot if any slot is enabled.
- R8: Otherwise a broadcast gives each slot whose latch is closed a request for the commanded state with power indicator on. Each slot whose latch is open gets power indicator off and keeps its state. The rule of R5 still decides whether a state moves.
- R9: All cmd_status bits clear when a new command executes. Codes outside the ranges above set invalid-command. The busy bit (0) and the latch-open bit (1) always read 0.
- R10: Every executed command, valid or not, sets cmd_detected. A control write (wr_addr=1, wr_be[0]=1, wr_data[0]=1) clears it. A clear that coincides with a command's execution loses to the set.
- R11: A command write (wr_en=1, wr_addr=0, any wr_be bit set) executes at the clock edge after the write edge, so its effects become visible one cycle after the write. A command write with wr_be=0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 selects the command word, 1 selects the control word |
| wr_be | input | 2 | Byte enables: bit 0 for the low byte (code), bit 1 for the high byte (target) |
| wr_data | input | 16 | Write data: [7:0] code and [15:8] target, or [0] detected-clear |
| slot_present | input | NUM_SLOTS | Card present per slot, sampled during reset |
| slot_latch_open | input | NUM_SLOTS | Retention latch open per slot |
| slot_state | output | 2*NUM_SLOTS | Packed per-slot state fields |
| slot_pwr_ind | output | 2*NUM_SLOTS | Packed per-slot power indicator fields |
| slot_attn_ind | output | 2*NUM_SLOTS | Packed per-slot attention indicator fields |
| cmd_status | output | 4 | Command status: busy, latch-open, invalid command, invalid mode |
| cmd_detected | output | 1 | Sticky flag set by every executed command |

## Verification
The assertions check on every cycle that each slot moves its state only along a legal transition, and that an enabled slot never falls to power-only. They also check that the busy and latch-open status bits stay clear, that status and the detected flag change only when a command executes, and that refused targets, refused broadcasts and speed codes leave every slot untouched. What only the bench's scenarios show is whether the values written are right: which indicator encodings land in which slot, how the latch pattern splits a broadcast, that status clears between commands, the execution latency, and the loss of a clear to a coinciding set.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

  typedef enum logic [1:0] {
    ST_KEEP     = 2'd0,
    ST_PWRONLY  = 2'd1,
    ST_ENABLED  = 2'd2,
    ST_DISABLED = 2'd3
  } slot_st_e;

  typedef enum logic [1:0] {
    IND_KEEP  = 2'd0,
    IND_ON    = 2'd1,
    IND_BLINK = 2'd2,
    IND_OFF   = 2'd3
  } ind_e;

  typedef enum logic [2:0] {
    CK_SLOT,
    CK_SPEED,
    CK_PWR_ALL,
    CK_EN_ALL,
    CK_BAD
  } cmd_kind_e;

  localparam int STAT_W       = 4;
  localparam int STAT_BUSY    = 0;
  localparam int STAT_LATCH   = 1;
  localparam int STAT_BADCMD  = 2;
  localparam int STAT_BADMODE = 3;
  localparam int TGT_W        = 5;

  localparam logic [7:0] CODE_PWR_ALL = 8'h48;
  localparam logic [7:0] CODE_EN_ALL  = 8'h49;

  function automatic cmd_kind_e classify(input logic [7:0] code);
    if (code[7:6] == 2'b00)        return CK_SLOT;
    if (code[7:3] == 5'b01000)     return CK_SPEED;
    if (code == CODE_PWR_ALL)      return CK_PWR_ALL;
    if (code == CODE_EN_ALL)       return CK_EN_ALL;
    return CK_BAD;
  endfunction

  // Legal moves only; anything else keeps the current state.
  function automatic slot_st_e next_state(input slot_st_e cur, input slot_st_e req);
    if (cur == ST_DISABLED && (req == ST_PWRONLY || req == ST_ENABLED)) return req;
    if ((cur == ST_ENABLED || cur == ST_PWRONLY) && req == ST_DISABLED) return ST_DISABLED;
    return cur;
  endfunction

  function automatic ind_e next_ind(input ind_e cur, input ind_e req);
    return (req == IND_KEEP) ? cur : req;
  endfunction

  function automatic logic rejects(input slot_st_e cur, input slot_st_e req);
    return (cur == ST_ENABLED) && (req == ST_PWRONLY);
  endfunction

endpackage

// File: rtl/hp_cmd_decode.sv
module hp_cmd_decode
  import hp_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic [7:0]                  code,
  input  logic [7:0]                  target,
  input  logic [NUM_SLOTS-1:0][1:0]   cur_st,
  input  logic [NUM_SLOTS-1:0]        latch_open,
  output cmd_kind_e                   kind,
  output logic                        any_enabled,
  output logic [NUM_SLOTS-1:0]        apply,
  output logic [NUM_SLOTS-1:0][1:0]   req_st,
  output logic [NUM_SLOTS-1:0][1:0]   req_pwr,
  output logic [NUM_SLOTS-1:0][1:0]   req_attn,
  output logic                        bad_cmd,
  output logic                        bad_mode
);

  logic [TGT_W-1:0]     tgt;
  logic [NUM_SLOTS-1:0] tgt_hit;
  logic [NUM_SLOTS-1:0] enabled_vec;
  logic [NUM_SLOTS-1:0] reject_vec;
  logic                 tgt_ok;
  logic                 tgt_rejects;
  logic                 unused_tgt_hi;

  assign tgt           = target[TGT_W-1:0];
  assign unused_tgt_hi = ^target[7:TGT_W];
  assign kind          = classify(code);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_dec
    assign tgt_hit[i]     = (tgt == TGT_W'(i + 1));
    assign enabled_vec[i] = (slot_st_e'(cur_st[i]) == ST_ENABLED);
    assign reject_vec[i]  = rejects(slot_st_e'(cur_st[i]), slot_st_e'(code[1:0]));
  end

  assign tgt_ok      = |tgt_hit;
  assign tgt_rejects = |(tgt_hit & reject_vec);
  assign any_enabled = |enabled_vec;

  always_comb begin
    apply    = '0;
    req_st   = '0;
    req_pwr  = '0;
    req_attn = '0;
    bad_cmd  = 1'b0;
    bad_mode = 1'b0;
    unique case (kind)
      CK_SLOT: begin
        if (!tgt_ok || tgt_rejects) begin
          bad_cmd = 1'b1;
        end else begin
          apply = tgt_hit;
          for (int i = 0; i < NUM_SLOTS; i++) begin
            req_st[i]   = code[1:0];
            req_pwr[i]  = code[3:2];
            req_attn[i] = code[5:4];
          end
        end
      end
      CK_SPEED: begin
        bad_mode = (code[2:0] != 3'd0);
      end
      CK_PWR_ALL, CK_EN_ALL: begin
        if (any_enabled) begin
          bad_cmd = 1'b1;
        end else begin
          apply = '1;
          for (int i = 0; i < NUM_SLOTS; i++) begin
            if (latch_open[i]) begin
              req_st[i]  = ST_KEEP;
              req_pwr[i] = IND_OFF;
            end else begin
              req_st[i]  = (kind == CK_EN_ALL) ? ST_ENABLED : ST_PWRONLY;
              req_pwr[i] = IND_ON;
            end
          end
        end
      end
      default: begin
        bad_cmd = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/hp_slot_unit.sv
module hp_slot_unit
  import hp_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       present,
  input  logic       apply,
  input  logic [1:0] req_st,
  input  logic [1:0] req_pwr,
  input  logic [1:0] req_attn,
  output logic [1:0] st_q,
  output logic [1:0] pwr_q,
  output logic [1:0] attn_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= present ? ST_ENABLED : ST_DISABLED;
      pwr_q  <= present ? IND_ON     : IND_OFF;
      attn_q <= IND_KEEP;
    end else if (apply) begin
      st_q   <= next_state(slot_st_e'(st_q), slot_st_e'(req_st));
      pwr_q  <= next_ind(ind_e'(pwr_q), ind_e'(req_pwr));
      attn_q <= next_ind(ind_e'(attn_q), ind_e'(req_attn));
    end
  end

  // R5
  legal_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st_q) |->
      (($past(st_q) == ST_DISABLED) && (st_q == ST_PWRONLY || st_q == ST_ENABLED)) ||
      (($past(st_q) != ST_DISABLED) && (st_q == ST_DISABLED)));

  // R4
  no_en_to_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ENABLED) |=> (st_q != ST_PWRONLY));

endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_addr,
  input  logic [1:0]              wr_be,
  input  logic [15:0]             wr_data,
  input  logic [NUM_SLOTS-1:0]    slot_present,
  input  logic [NUM_SLOTS-1:0]    slot_latch_open,
  output logic [2*NUM_SLOTS-1:0]  slot_state,
  output logic [2*NUM_SLOTS-1:0]  slot_pwr_ind,
  output logic [2*NUM_SLOTS-1:0]  slot_attn_ind,
  output logic [STAT_W-1:0]       cmd_status,
  output logic                    cmd_detected
);

  localparam int FW = 2;

  logic [7:0]        code_q;
  logic [7:0]        tgt_q;
  logic              pend_q;
  logic [STAT_W-1:0] status_q;
  logic              det_q;

  logic cmd_wr;
  logic det_clr;

  cmd_kind_e                  kind;
  logic                       any_en;
  logic [NUM_SLOTS-1:0]       dec_apply;
  logic [NUM_SLOTS-1:0]       slot_apply;
  logic [NUM_SLOTS-1:0][1:0]  cur_st;
  logic [NUM_SLOTS-1:0][1:0]  req_st;
  logic [NUM_SLOTS-1:0][1:0]  req_pwr;
  logic [NUM_SLOTS-1:0][1:0]  req_attn;
  logic                       bad_cmd;
  logic                       bad_mode;

  assign cmd_wr  = wr_en && !wr_addr && (|wr_be);
  assign det_clr = wr_en && wr_addr && wr_be[0] && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      tgt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= cmd_wr;
      if (cmd_wr && wr_be[0]) code_q <= wr_data[7:0];
      if (cmd_wr && wr_be[1]) tgt_q  <= wr_data[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      det_q    <= 1'b0;
    end else begin
      if (pend_q) begin
        status_q                <= '0;
        status_q[STAT_BADCMD]   <= bad_cmd;
        status_q[STAT_BADMODE]  <= bad_mode;
        det_q                   <= 1'b1;
      end else if (det_clr) begin
        det_q <= 1'b0;
      end
    end
  end

  hp_cmd_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
    .code        (code_q),
    .target      (tgt_q),
    .cur_st      (cur_st),
    .latch_open  (slot_latch_open),
    .kind        (kind),
    .any_enabled (any_en),
    .apply       (dec_apply),
    .req_st      (req_st),
    .req_pwr     (req_pwr),
    .req_attn    (req_attn),
    .bad_cmd     (bad_cmd),
    .bad_mode    (bad_mode)
  );

  assign slot_apply = {NUM_SLOTS{pend_q}} & dec_apply;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [1:0] st_w;
    logic [1:0] pwr_w;
    logic [1:0] attn_w;

    hp_slot_unit u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .present  (slot_present[i]),
      .apply    (slot_apply[i]),
      .req_st   (req_st[i]),
      .req_pwr  (req_pwr[i]),
      .req_attn (req_attn[i]),
      .st_q     (st_w),
      .pwr_q    (pwr_w),
      .attn_q   (attn_w)
    );

    assign cur_st[i]               = st_w;
    assign slot_state[FW*i +: FW]    = st_w;
    assign slot_pwr_ind[FW*i +: FW]  = pwr_w;
    assign slot_attn_ind[FW*i +: FW] = attn_w;
  end

  assign cmd_status   = status_q;
  assign cmd_detected = det_q;

  // R9
  stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_status[STAT_LATCH:STAT_BUSY] == 2'b00);

  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(cmd_status));

  // R10
  detect_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_detected) |-> $past(pend_q));

  // R7
  bcast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && (kind == CK_PWR_ALL || kind == CK_EN_ALL) && any_en)
      |=> ($stable(slot_state) && $stable(slot_pwr_ind) && cmd_status[STAT_BADCMD]));

  // R3
  bad_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && kind == CK_SLOT && bad_cmd)
      |=> ($stable(slot_state) && $stable(slot_pwr_ind) && $stable(slot_attn_ind)));

  // R6
  speed_no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && kind == CK_SPEED)
      |=> ($stable(slot_state) && !cmd_status[STAT_BADCMD]));

endmodule

// File: tb/hp_slot_ctrl_bench.sv
module hp_slot_ctrl_bench;

  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic           wr_addr = 1'b0;
  logic [1:0]     wr_be = 2'b00;
  logic [15:0]    wr_data = 16'h0;
  logic [N-1:0]   slot_present = 4'b0101;
  logic [N-1:0]   slot_latch_open = 4'b1010;
  logic [2*N-1:0] slot_state;
  logic [2*N-1:0] slot_pwr_ind;
  logic [2*N-1:0] slot_attn_ind;
  logic [3:0]     cmd_status;
  logic           cmd_detected;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hp_slot_ctrl #(.NUM_SLOTS(N)) u_hp_slot_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_be           (wr_be),
    .wr_data         (wr_data),
    .slot_present    (slot_present),
    .slot_latch_open (slot_latch_open),
    .slot_state      (slot_state),
    .slot_pwr_ind    (slot_pwr_ind),
    .slot_attn_ind   (slot_attn_ind),
    .cmd_status      (cmd_status),
    .cmd_detected    (cmd_detected)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st[N];
  int m_pw[N];
  int m_at[N];
  int m_stat;
  int m_det;
  int m_code;
  int m_tgt;
  int m_pend;

  function automatic int packf(input int v[N]);
    int r = 0;
    for (int i = 0; i < N; i++) r += (v[i] & 3) << (2 * i);
    return r;
  endfunction

  task automatic model_slot(input int s, input int rq, input int p, input int a);
    if (p != 0) m_pw[s] = p;
    if (a != 0) m_at[s] = a;
    if (m_st[s] == 3 && (rq == 1 || rq == 2)) m_st[s] = rq;
    else if ((m_st[s] == 2 || m_st[s] == 1) && rq == 3) m_st[s] = 3;
  endtask

  task automatic model_exec();
    int t;
    int anyen;
    m_stat = 0;
    m_det = 1;
    if (m_code < 64) begin
      t = m_tgt % 32;
      if (t == 0 || t > N) m_stat = 4;
      else if (m_st[t-1] == 2 && (m_code % 4) == 1) m_stat = 4;
      else model_slot(t - 1, m_code % 4, (m_code / 4) % 4, (m_code / 16) % 4);
    end else if (m_code >= 64 && m_code <= 71) begin
      if ((m_code % 8) != 0) m_stat = 8;
    end else if (m_code == 72 || m_code == 73) begin
      anyen = 0;
      for (int i = 0; i < N; i++) if (m_st[i] == 2) anyen = 1;
      if (anyen != 0) m_stat = 4;
      else begin
        for (int i = 0; i < N; i++) begin
          if (slot_latch_open[i]) model_slot(i, 0, 3, 0);
          else model_slot(i, (m_code == 73) ? 2 : 1, 1, 0);
        end
      end
    end else begin
      m_stat = 4;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = slot_present[i] ? 2 : 3;
        m_pw[i] = slot_present[i] ? 1 : 3;
        m_at[i] = 0;
      end
      m_stat = 0; m_det = 0; m_code = 0; m_tgt = 0; m_pend = 0;
    end else begin
      if (wr_en && wr_addr && wr_be[0] && wr_data[0]) m_det = 0;
      if (m_pend != 0) model_exec();
      if (wr_en && !wr_addr && wr_be != 2'b00) begin
        if (wr_be[0]) m_code = int'(wr_data[7:0]);
        if (wr_be[1]) m_tgt  = int'(wr_data[15:8]);
        m_pend = 1;
      end else begin
        m_pend = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(slot_state) == packf(m_st), "R2/R5 model state", int'(slot_state), packf(m_st));
      chk(int'(slot_pwr_ind) == packf(m_pw), "R2/R8 model power", int'(slot_pwr_ind), packf(m_pw));
      chk(int'(slot_attn_ind) == packf(m_at), "R2 model attention", int'(slot_attn_ind), packf(m_at));
      chk(int'(cmd_status) == m_stat, "R9 model status", int'(cmd_status), m_stat);
      chk(int'(cmd_detected) == m_det, "R10 model detected", int'(cmd_detected), m_det);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr_cmd(input logic [7:0] code, input logic [7:0] tgt);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_be = 2'b11; wr_data = {tgt, code};
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic bit0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b1; wr_be = 2'b01; wr_data = {15'h0, bit0};
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00; wr_addr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(slot_state == 8'hEE, "R1 reset state", int'(slot_state), 'hEE);
    chk(slot_pwr_ind == 8'hDD, "R1 reset power", int'(slot_pwr_ind), 'hDD);
    chk(slot_attn_ind == 8'h00, "R1 reset attention", int'(slot_attn_ind), 0);
    chk(cmd_status == 4'h0 && !cmd_detected, "R1 reset status/flag",
        int'({cmd_detected, cmd_status}), 0);

    // R11 latency: nothing at the write edge, result one edge later
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_be = 2'b11; wr_data = {8'h02, 8'h21};
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
    chk(slot_state == 8'hEE && !cmd_detected, "R11 not yet executed", int'(slot_state), 'hEE);
    @(negedge clk);
    chk(slot_state == 8'hE6, "R11 executed one cycle later", int'(slot_state), 'hE6);
    chk(slot_attn_ind == 8'h08, "R2 attention blink on slot 1", int'(slot_attn_ind), 'h08);
    chk(cmd_detected == 1'b1, "R10 detected set", int'(cmd_detected), 1);

    // R4 enabled -> power-only refused, indicators untouched
    wr_cmd(8'h0D, 8'd1);
    chk(cmd_status == 4'h4, "R4 invalid status", int'(cmd_status), 4);
    chk(slot_state == 8'hE6 && slot_pwr_ind == 8'hDD, "R4 slot untouched",
        int'({slot_state, slot_pwr_ind}), 'hE6DD);

    // R3 target range and masking
    wr_cmd(8'h03, 8'd0);
    chk(cmd_status == 4'h4, "R3 target zero", int'(cmd_status), 4);
    wr_cmd(8'h03, 8'd5);
    chk(cmd_status == 4'h4 && slot_state == 8'hE6, "R3 target above count",
        int'({cmd_status, slot_state}), 'h4E6);
    wr_cmd(8'h08, 8'h22);
    chk(cmd_status == 4'h0 && slot_pwr_ind == 8'hD9, "R3 low five target bits",
        int'({cmd_status, slot_pwr_ind}), 'h0D9);

    // R5 illegal move keeps state, applies indicators; legal disable
    wr_cmd(8'h32, 8'd2);
    chk(slot_state == 8'hE6 && slot_attn_ind == 8'h0C, "R5 keep state, apply attention",
        int'({slot_state, slot_attn_ind}), 'hE60C);
    wr_cmd(8'h03, 8'd2);
    chk(slot_state == 8'hEE, "R5 power-only to disabled", int'(slot_state), 'hEE);

    // R6 speed codes
    wr_cmd(8'h40, 8'd0);
    chk(cmd_status == 4'h0, "R6 speed zero accepted", int'(cmd_status), 0);
    wr_cmd(8'h45, 8'd0);
    chk(cmd_status == 4'h8 && slot_state == 8'hEE, "R6 bad speed", int'(cmd_status), 8);

    // R9 unknown codes and status clearing
    wr_cmd(8'h80, 8'd0);
    chk(cmd_status == 4'h4, "R9 unknown code", int'(cmd_status), 4);
    wr_cmd(8'h40, 8'd0);
    chk(cmd_status == 4'h0, "R9 status cleared", int'(cmd_status), 0);
    wr_cmd(8'h4A, 8'd0);
    chk(cmd_status == 4'h4, "R9 code 0x4A invalid", int'(cmd_status), 4);
    wr_cmd(8'h47, 8'd0);
    chk(cmd_status == 4'h8, "R9 previous bit cleared", int'(cmd_status), 8);

    // R7 broadcast refused while slots enabled
    wr_cmd(8'h48, 8'd0);
    chk(cmd_status == 4'h4 && slot_state == 8'hEE && slot_pwr_ind == 8'hD9,
        "R7 broadcast refused", int'({cmd_status, slot_state, slot_pwr_ind}), 'h4EED9);

    // R8 enable-all split by latch
    wr_cmd(8'h03, 8'd1);
    wr_cmd(8'h03, 8'd3);
    chk(slot_state == 8'hFF, "R5 all disabled", int'(slot_state), 'hFF);
    wr_cmd(8'h49, 8'd0);
    chk(slot_state == 8'hEE && slot_pwr_ind == 8'hDD && cmd_status == 4'h0,
        "R8 enable-all", int'({slot_state, slot_pwr_ind}), 'hEEDD);
    wr_cmd(8'h48, 8'd0);
    chk(cmd_status == 4'h4, "R7 power-only-all refused", int'(cmd_status), 4);
    wr_cmd(8'h03, 8'd1);
    wr_cmd(8'h03, 8'd3);
    wr_cmd(8'h48, 8'd0);
    chk(slot_state == 8'hDD && slot_pwr_ind == 8'hDD, "R8 power-only-all",
        int'({slot_state, slot_pwr_ind}), 'hDDDD);
    wr_cmd(8'h49, 8'd0);
    chk(slot_state == 8'hDD && cmd_status == 4'h0, "R8 enable-all keeps power-only",
        int'({cmd_status, slot_state}), 'h0DD);

    // R10 clear, no-op clear, set wins
    wr_ctl(1'b1);
    @(negedge clk);
    chk(cmd_detected == 1'b0, "R10 write-one clears", int'(cmd_detected), 0);
    wr_cmd(8'h40, 8'd0);
    wr_ctl(1'b0);
    @(negedge clk);
    chk(cmd_detected == 1'b1, "R10 write-zero ignored", int'(cmd_detected), 1);
    wr_ctl(1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_be = 2'b11; wr_data = {8'h00, 8'h40};
    @(negedge clk);
    wr_addr = 1'b1; wr_be = 2'b01; wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00; wr_addr = 1'b0;
    chk(cmd_detected == 1'b1, "R10 set wins over clear", int'(cmd_detected), 1);

    // R11 command write with no byte enables
    wr_ctl(1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_be = 2'b00; wr_data = {8'h01, 8'h80};
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    chk(cmd_detected == 1'b0 && cmd_status == 4'h0, "R11 zero enables ignored",
        int'({cmd_detected, cmd_status}), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule